// File: doc/BRIEF.md
# Synthesizer Configuration Serial Port

This block is the write-only configuration port of a two-channel frequency synthesizer. A host drives three wires: a serial clock, a serial data line and a load strobe. Data bits are shifted into a 22-bit word, most significant bit first. When the load strobe rises, the word is copied into one of four holding latches. The two bits shifted in last select the latch: a divider latch and a counter latch for each of the two channels.

A divider latch holds a 14-bit reference division ratio and three bits that set up the phase detector and charge pump. A counter latch holds the 6-bit swallow count, the 11-bit main count, the prescaler modulus select and the channel power-down bit. Every latched field leaves the block as a plain output that drives the counters and analog controls.

The three serial wires are asynchronous to the system clock. They pass through synchronizers, and the block detects their rising edges in the system clock domain. For this reason the serial clock must run several times slower than the system clock.

Top module: `synth_cfg_port`

## Requirements
- R1: Each detected rising edge of the serial clock shifts the synchronized data bit into bit 0 of the 22-bit word, moving earlier bits toward bit 21. Data therefore enters most significant bit first.
- R2: On a detected rising edge of the load strobe, the word is copied into the latch selected by word bits [1:0]:
  - 00 selects the channel-2 divider latch.
  - 01 selects the channel-2 counter latch.
  - 10 selects the channel-1 divider latch.
  - 11 selects the channel-1 counter latch.
- R3: A divider latch takes its fields from the word as follows:
  - reference ratio from bits [15:2];
  - phase detector polarity from bit 16;
  - charge-pump three-state from bit 17;
  - charge-pump current select from bit 18.
- R4: A counter latch takes its fields from the word as follows:
  - swallow count from bits [7:2];
  - main count from bits [18:8];
  - prescaler select from bit 19 (0 selects 64/65, 1 selects 32/33);
  - power-down from bit 20.
- R5: A load leaves the three latches it does not select unchanged.
- R6: After reset, every latched output is zero.
- R7: Holding the load strobe high causes only one transfer. Serial bits shifted while it stays high are not transferred until the strobe falls and rises again.
- R8: A load that arrives after fewer than 22 serial clocks since the previous load still transfers the current word. That word is the last 22 bits shifted, older bits included.
- R9: When a serial clock edge and a load edge are detected in the same system cycle, the latch receives the word as it was before that shift. The bit is then still shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe, acts on rising edge |
| ch1_rdiv | output | 14 | Channel-1 reference ratio |
| ch1_pd_pol | output | 1 | Channel-1 phase detector polarity |
| ch1_cp_tri | output | 1 | Channel-1 charge-pump three-state |
| ch1_cp_cur | output | 1 | Channel-1 charge-pump current select |
| ch1_adiv | output | 6 | Channel-1 swallow count |
| ch1_bdiv | output | 11 | Channel-1 main count |
| ch1_pre_sel | output | 1 | Channel-1 prescaler select |
| ch1_pwr_dn | output | 1 | Channel-1 power-down |
| ch2_rdiv | output | 14 | Channel-2 reference ratio |
| ch2_pd_pol | output | 1 | Channel-2 phase detector polarity |
| ch2_cp_tri | output | 1 | Channel-2 charge-pump three-state |
| ch2_cp_cur | output | 1 | Channel-2 charge-pump current select |
| ch2_adiv | output | 6 | Channel-2 swallow count |
| ch2_bdiv | output | 11 | Channel-2 main count |
| ch2_pre_sel | output | 1 | Channel-2 prescaler select |
| ch2_pwr_dn | output | 1 | Channel-2 power-down |

## Verification
A shift and a latch transfer can happen in the same system cycle when the serial clock and the load strobe rise together. The bench provokes this by raising both wires at the same system-clock edge, so that both pass through equal synchronizer depth. The outcome is judged in two steps:
- The destination latch must show the word as it stood before that bit.
- A following load, with no further serial clocks, must show the word that includes the bit.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int WORD_W = 22;
  localparam int CTRL_W = 2;
  localparam int R_W    = 14;
  localparam int A_W    = 6;
  localparam int B_W    = 11;

  typedef enum logic [CTRL_W-1:0] {
    DST_CH2_REF = 2'b00,
    DST_CH2_AB  = 2'b01,
    DST_CH1_REF = 2'b10,
    DST_CH1_AB  = 2'b11
  } dest_e;

  typedef struct packed {
    logic           cp_cur;
    logic           cp_tri;
    logic           pd_pol;
    logic [R_W-1:0] rdiv;
  } ref_cfg_t;

  typedef struct packed {
    logic           pwr_dn;
    logic           pre_sel;
    logic [B_W-1:0] bdiv;
    logic [A_W-1:0] adiv;
  } ab_cfg_t;

  localparam int REF_W = $bits(ref_cfg_t);
  localparam int AB_W  = $bits(ab_cfg_t);
endpackage

// File: rtl/cfg_bit_sync.sv
module cfg_bit_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= d;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter
  import synth_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              din,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {sr_q[WORD_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign word = sr_q;

  // R1: a detected edge moves the word up by one and takes the new bit at the bottom
  p_shift_msb_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (sr_q[WORD_W-1:1] == $past(sr_q[WORD_W-2:0])) && (sr_q[0] == $past(din)));

  // R1: no edge, no movement
  p_shift_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr_q));
endmodule

// File: rtl/cfg_latches.sv
module cfg_latches
  import synth_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output ref_cfg_t          ch1_ref,
  output ref_cfg_t          ch2_ref,
  output ab_cfg_t           ch1_ab,
  output ab_cfg_t           ch2_ab
);
  localparam int NCH   = 2;
  localparam int NDEST = 1 << CTRL_W;

  dest_e            dest;
  logic [NDEST-1:0] sel;
  ref_cfg_t         ref_q [NCH];
  ref_cfg_t         ref_d [NCH];
  ab_cfg_t          ab_q  [NCH];
  ab_cfg_t          ab_d  [NCH];

  assign dest = dest_e'(word[CTRL_W-1:0]);

  always_comb begin
    sel = '0;
    if (load) sel[dest] = 1'b1;
  end

  // channel index 0 is channel 1 (codes 1x), index 1 is channel 2 (codes 0x)
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int REF_BIT = 2 - 2*c;
    localparam int AB_BIT  = 3 - 2*c;

    always_comb begin
      ref_d[c] = ref_q[c];
      ab_d[c]  = ab_q[c];
      if (sel[REF_BIT]) ref_d[c] = ref_cfg_t'(word[CTRL_W +: REF_W]);
      if (sel[AB_BIT])  ab_d[c]  = ab_cfg_t'(word[CTRL_W +: AB_W]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_q[c] <= '0;
        ab_q[c]  <= '0;
      end else begin
        ref_q[c] <= ref_d[c];
        ab_q[c]  <= ab_d[c];
      end
    end

    // R3: divider latch captures the word slice when addressed
    p_ref_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && word[1:0] == 2'(REF_BIT)) |=> ref_q[c] == $past(word[CTRL_W +: REF_W]));

    // R4: counter latch captures the word slice when addressed
    p_ab_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && word[1:0] == 2'(AB_BIT)) |=> ab_q[c] == $past(word[CTRL_W +: AB_W]));

    // R5: an unaddressed latch holds
    p_ref_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && word[1:0] == 2'(REF_BIT)) |=> $stable(ref_q[c]));
    p_ab_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && word[1:0] == 2'(AB_BIT)) |=> $stable(ab_q[c]));
  end

  // R2: at most one destination per load
  p_one_dest_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel));

  assign ch1_ref = ref_q[0];
  assign ch2_ref = ref_q[1];
  assign ch1_ab  = ab_q[0];
  assign ch2_ab  = ab_q[1];
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_le,
  output logic [R_W-1:0] ch1_rdiv,
  output logic           ch1_pd_pol,
  output logic           ch1_cp_tri,
  output logic           ch1_cp_cur,
  output logic [A_W-1:0] ch1_adiv,
  output logic [B_W-1:0] ch1_bdiv,
  output logic           ch1_pre_sel,
  output logic           ch1_pwr_dn,
  output logic [R_W-1:0] ch2_rdiv,
  output logic           ch2_pd_pol,
  output logic           ch2_cp_tri,
  output logic           ch2_cp_cur,
  output logic [A_W-1:0] ch2_adiv,
  output logic [B_W-1:0] ch2_bdiv,
  output logic           ch2_pre_sel,
  output logic           ch2_pwr_dn
);
  logic [1:0]        rst_ff;
  logic              rst_n_s;
  logic [2:0]        pins_s;
  logic              sclk_s, sdat_s, le_s;
  logic              sclk_prev, le_prev;
  logic              sclk_rise, le_rise;
  logic [WORD_W-1:0] word;
  ref_cfg_t          ch1_ref, ch2_ref;
  ab_cfg_t           ch1_ab, ch2_ab;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_n_s = rst_ff[1];

  cfg_bit_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d     ({ser_le, ser_data, ser_clk}),
    .q     (pins_s)
  );
  assign {le_s, sdat_s, sclk_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sclk_prev <= 1'b0;
      le_prev   <= 1'b0;
    end else begin
      sclk_prev <= sclk_s;
      le_prev   <= le_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_prev;
  assign le_rise   = le_s & ~le_prev;

  cfg_shifter i_shift (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .shift_en (sclk_rise),
    .din      (sdat_s),
    .word     (word)
  );

  cfg_latches i_latch (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (le_rise),
    .word    (word),
    .ch1_ref (ch1_ref),
    .ch2_ref (ch2_ref),
    .ch1_ab  (ch1_ab),
    .ch2_ab  (ch2_ab)
  );

  // R7: a load is a single cycle event per strobe rise
  p_load_single_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    le_rise |=> !le_rise);

  assign ch1_rdiv    = ch1_ref.rdiv;
  assign ch1_pd_pol  = ch1_ref.pd_pol;
  assign ch1_cp_tri  = ch1_ref.cp_tri;
  assign ch1_cp_cur  = ch1_ref.cp_cur;
  assign ch1_adiv    = ch1_ab.adiv;
  assign ch1_bdiv    = ch1_ab.bdiv;
  assign ch1_pre_sel = ch1_ab.pre_sel;
  assign ch1_pwr_dn  = ch1_ab.pwr_dn;
  assign ch2_rdiv    = ch2_ref.rdiv;
  assign ch2_pd_pol  = ch2_ref.pd_pol;
  assign ch2_cp_tri  = ch2_ref.cp_tri;
  assign ch2_cp_cur  = ch2_ref.cp_cur;
  assign ch2_adiv    = ch2_ab.adiv;
  assign ch2_bdiv    = ch2_ab.bdiv;
  assign ch2_pre_sel = ch2_ab.pre_sel;
  assign ch2_pwr_dn  = ch2_ab.pwr_dn;
endmodule

// File: tb/test_synth_cfg_port.sv
`timescale 1ns/1ps
module test_synth_cfg_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [13:0] ch1_rdiv, ch2_rdiv;
  logic ch1_pd_pol, ch1_cp_tri, ch1_cp_cur, ch2_pd_pol, ch2_cp_tri, ch2_cp_cur;
  logic [5:0]  ch1_adiv, ch2_adiv;
  logic [10:0] ch1_bdiv, ch2_bdiv;
  logic ch1_pre_sel, ch1_pwr_dn, ch2_pre_sel, ch2_pwr_dn;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model: shifted word and the four latches (full 22-bit words)
  logic [21:0] m_sr = '0;
  logic [21:0] m_lat [4] = '{default: '0};

  always #2.5 clk = ~clk;

  synth_cfg_port i_synth_cfg_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .ch1_rdiv(ch1_rdiv), .ch1_pd_pol(ch1_pd_pol), .ch1_cp_tri(ch1_cp_tri), .ch1_cp_cur(ch1_cp_cur),
    .ch1_adiv(ch1_adiv), .ch1_bdiv(ch1_bdiv), .ch1_pre_sel(ch1_pre_sel), .ch1_pwr_dn(ch1_pwr_dn),
    .ch2_rdiv(ch2_rdiv), .ch2_pd_pol(ch2_pd_pol), .ch2_cp_tri(ch2_cp_tri), .ch2_cp_cur(ch2_cp_cur),
    .ch2_adiv(ch2_adiv), .ch2_bdiv(ch2_bdiv), .ch2_pre_sel(ch2_pre_sel), .ch2_pwr_dn(ch2_pwr_dn)
  );

  // R3 field positions: ratio [15:2], polarity 16, three-state 17, current 18
  function automatic logic [16:0] exp_ref(input logic [21:0] w);
    return {w[18], w[17], w[16], w[15:2]};
  endfunction
  // R4 field positions: swallow [7:2], main [18:8], prescaler 19, power-down 20
  function automatic logic [18:0] exp_ab(input logic [21:0] w);
    return {w[20], w[19], w[18:8], w[7:2]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compare all four latches against the model (latch index = code)
  task automatic check_all(input string req);
    chk({req, " ch2 ref"}, 32'({ch2_cp_cur, ch2_cp_tri, ch2_pd_pol, ch2_rdiv}), 32'(exp_ref(m_lat[0])));
    chk({req, " ch2 ab"},  32'({ch2_pwr_dn, ch2_pre_sel, ch2_bdiv, ch2_adiv}),   32'(exp_ab(m_lat[1])));
    chk({req, " ch1 ref"}, 32'({ch1_cp_cur, ch1_cp_tri, ch1_pd_pol, ch1_rdiv}), 32'(exp_ref(m_lat[2])));
    chk({req, " ch1 ab"},  32'({ch1_pwr_dn, ch1_pre_sel, ch1_bdiv, ch1_adiv}),   32'(exp_ab(m_lat[3])));
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_data = b;
    wait_clk(4);
    ser_clk = 1'b1;
    wait_clk(4);
    ser_clk = 1'b0;
    m_sr = {m_sr[20:0], b};
  endtask

  task automatic send_bits(input logic [21:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_le();
    wait_clk(2);
    ser_le = 1'b1;
    m_lat[m_sr[1:0]] = m_sr;
    wait_clk(4);
    ser_le = 1'b0;
    wait_clk(8);
  endtask

  task automatic write_word(input logic [21:0] w);
    send_bits(w, 22);
    pulse_le();
  endtask

  initial begin
    logic [21:0] w;
    void'($urandom(32'd20240607));
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(6);
    check_all("R6 reset");

    // directed: one word per destination, distinct field patterns
    write_word({1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 14'h2ABC, 2'b10});
    check_all("R3 R2 ch1 ref");
    write_word({1'b0, 1'b1, 1'b0, 11'h5A3, 6'h2D, 2'b11});
    check_all("R4 R1 ch1 ab");
    write_word({1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 14'h3FFF, 2'b00});
    check_all("R3 R5 ch2 ref");
    write_word({1'b0, 1'b0, 1'b1, 11'h7FF, 6'h01, 2'b01});
    check_all("R4 R5 ch2 ab");

    // constrained random words across all destinations
    for (int k = 0; k < 24; k++) begin
      w = 22'($urandom);
      write_word(w);
      check_all("R2 R5 random");
    end

    // short write: only 7 clocks since the last load
    send_bits(22'h0000_4E, 7);
    pulse_le();
    check_all("R8 short write");

    // strobe held high: one transfer, later bits wait for the next rise
    send_bits({2'b00, 20'h1_2345} | 22'h3, 22);
    wait_clk(2);
    ser_le = 1'b1;
    m_lat[m_sr[1:0]] = m_sr;
    wait_clk(10);
    send_bits(22'h15_5552, 22);
    wait_clk(8);
    check_all("R7 held strobe");
    ser_le = 1'b0;
    wait_clk(4);
    pulse_le();
    check_all("R7 after new rise");

    // same-cycle shift and load edge
    send_bits(22'h0A_BCD1, 22);
    wait_clk(2);
    ser_data = 1'b1;
    wait_clk(4);
    ser_clk = 1'b1;
    ser_le  = 1'b1;
    m_lat[m_sr[1:0]] = m_sr;
    m_sr = {m_sr[20:0], 1'b1};
    wait_clk(4);
    ser_clk = 1'b0;
    ser_le  = 1'b0;
    wait_clk(8);
    check_all("R9 load before shift");
    pulse_le();
    check_all("R9 bit kept");

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule